// File: doc/BRIEF.md
# Keyed Flow Hash Unit

This unit turns a 352-bit flow tuple into the two 16-bit keyed hashes that a packet-classification filter table needs: a bucket index that selects where a filter lives, and a tag that tells filters in the same bucket apart. The tuple is presented as eleven 32-bit words. Word 0 holds the flow type, pool and VLAN identifier. Words 1 to 10 hold the addresses, ports and flexible bytes.

The words are folded into a high and a low 32-bit word. The flow/VLAN word is mixed into each of them at its own stage. A 32-bit key then gates a shift-and-XOR over sixteen positions. The same fold is hashed twice, once with a bucket key and once with a signature key. The bucket hash is masked to a width set by both the table size and the match mode. In signature mode, the upper half of the result word carries the signature hash. In perfect-match mode, a caller-supplied 16-bit software index takes its place.

A request is accepted through a valid/ready handshake. The result appears one clock later, qualified by a single-cycle valid pulse, and holds until the next accepted request.

Top module: `flow_hash_top`

## Requirements
- R1: Words 1 to 10 affect the hashes only through their bitwise XOR. Reordering those words, or XORing the same value into two of them, leaves both outputs unchanged.
- R2: With common word C and flow word F, the high word is C ^ F ^ (F >> 16). The low word used for key bit 0 is C with its 16-bit halves swapped, with no F term. The low word used for key bits 1 to 15 is that swapped word ^ F ^ (F << 16).
- R3: A key with only bit 0 set yields hash = C[31:16] whatever F is. A key with only bit 16 set yields the low 16 bits of the high word. An all-zero key yields hash 0.
- R4: For each i from 1 to 15, key bit i XORs bits [15:0] of (low word >> i) into the hash, and key bit i+16 XORs bits [15:0] of (high word >> i) into it. The hash is the XOR of all enabled terms.
- R5: Table-size select codes are 2'b01, 2'b10 and 2'b11. In signature mode (perfect_mode = 0), these keep 13, 14 and 15 low bits of the bucket hash, and the bits above are zero.
- R6: In perfect mode (perfect_mode = 1), the same three codes keep 11, 12 and 13 low bits of the bucket hash.
- R7: In signature mode, out_hash[31:16] is the signature-key hash and out_hash[15:0] equals out_bucket.
- R8: In perfect mode, out_hash[31:16] is sw_index and out_hash[15:0] equals out_bucket.
- R9: out_valid is high for exactly the one cycle after each cycle where in_valid and in_ready are both high, and is low otherwise. Result outputs hold their values between accepted requests.
- R10: Table-size code 2'b00 is rejected. The result cycle shows out_error = 1 with out_bucket and out_hash both zero. A valid code gives out_error = 0.
- R11: in_ready is low while rst_n is low and high from the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request |
| tuple | input | 352 | Flow tuple; word w is bits [32w+31:32w] |
| bucket_key | input | 32 | Key for the bucket hash |
| sig_key | input | 32 | Key for the signature hash |
| tbl_size | input | 2 | Table size: 01, 10 or 11 (00 is an error) |
| perfect_mode | input | 1 | 1 = perfect match, 0 = signature |
| sw_index | input | 16 | Software index used in perfect mode |
| out_valid | output | 1 | One-cycle result strobe |
| out_bucket | output | 16 | Masked bucket index, zero-padded |
| out_hash | output | 32 | Upper field over masked bucket |
| out_error | output | 1 | Request used an illegal table size |

## Verification
The clocked properties assume that tbl_size, perfect_mode, sw_index and sig_key are known in the cycle a request is accepted. They compare each result with the registered copy of those inputs taken one cycle earlier, so the inputs may change freely between requests. The stimulus sets all request fields at a falling edge together with in_valid and holds them through the capturing edge. It uses only known values, and drops in_valid after one cycle, so every result has a single request behind it.

// File: rtl/flow_hash_pkg.sv
package flow_hash_pkg;

    localparam int FH_WORD_W    = 32;
    localparam int FH_NUM_WORDS = 11;
    localparam int FH_HASH_W    = 16;
    localparam int FH_SIZE_W    = 2;
    localparam int FH_PERF_BASE = 11;
    localparam int FH_SIG_BASE  = 13;

    typedef struct packed {
        logic                     ready;
        logic                     valid;
        logic                     error;
        logic [FH_HASH_W-1:0]     bucket;
        logic [2*FH_HASH_W-1:0]   hash;
    } fh_state_t;

endpackage

// File: rtl/flow_hash_fold.sv
module flow_hash_fold #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 11
) (
    input  logic [WORD_W*NUM_WORDS-1:0] tuple_i,
    output logic [WORD_W-1:0]           hi_o,
    output logic [WORD_W-1:0]           lo_plain_o,
    output logic [WORD_W-1:0]           lo_mixed_o
);
    localparam int HALF = WORD_W / 2;

    logic [WORD_W-1:0] chain [NUM_WORDS];
    logic [WORD_W-1:0] flow_w;
    logic [WORD_W-1:0] common_w;

    assign chain[0] = '0;

    generate
        for (genvar w = 1; w < NUM_WORDS; w++) begin : g_fold
            assign chain[w] = chain[w-1] ^ tuple_i[w*WORD_W +: WORD_W];
        end
    endgenerate

    always_comb begin
        flow_w     = tuple_i[WORD_W-1:0];
        common_w   = chain[NUM_WORDS-1];
        hi_o       = common_w ^ flow_w ^ (flow_w >> HALF);
        lo_plain_o = {common_w[HALF-1:0], common_w[WORD_W-1:HALF]};
        lo_mixed_o = lo_plain_o ^ flow_w ^ (flow_w << HALF);
    end

endmodule

// File: rtl/flow_hash_keyed.sv
module flow_hash_keyed #(
    parameter int WORD_W = 32,
    parameter int HASH_W = 16
) (
    input  logic [WORD_W-1:0] key_i,
    input  logic [WORD_W-1:0] hi_i,
    input  logic [WORD_W-1:0] lo_plain_i,
    input  logic [WORD_W-1:0] lo_mixed_i,
    output logic [HASH_W-1:0] hash_o
);
    localparam int HALF = WORD_W / 2;

    logic [WORD_W-1:0] acc [HALF];
    logic              unused_acc_hi;

    assign acc[0] = (key_i[0]    ? lo_plain_i : '0) ^
                    (key_i[HALF] ? hi_i       : '0);

    generate
        for (genvar i = 1; i < HALF; i++) begin : g_step
            assign acc[i] = acc[i-1] ^
                            (key_i[i]      ? (lo_mixed_i >> i) : '0) ^
                            (key_i[i+HALF] ? (hi_i       >> i) : '0);
        end
    endgenerate

    assign hash_o        = acc[HALF-1][HASH_W-1:0];
    assign unused_acc_hi = ^acc[HALF-1][WORD_W-1:HASH_W];

endmodule

// File: rtl/flow_hash_compose.sv
module flow_hash_compose #(
    parameter int HASH_W    = 16,
    parameter int SIZE_W    = 2,
    parameter int PERF_BASE = 11,
    parameter int SIG_BASE  = 13
) (
    input  logic [HASH_W-1:0]   bucket_raw_i,
    input  logic [HASH_W-1:0]   sig_raw_i,
    input  logic [SIZE_W-1:0]   tbl_size_i,
    input  logic                perfect_i,
    input  logic [HASH_W-1:0]   sw_index_i,
    output logic [HASH_W-1:0]   bucket_o,
    output logic [2*HASH_W-1:0] word_o,
    output logic                error_o
);
    localparam int WID_W = $clog2(HASH_W + 1) + 1;

    logic [WID_W-1:0]  keep_w;
    logic [HASH_W-1:0] mask;

    always_comb begin
        error_o = (tbl_size_i == '0);
        keep_w  = (perfect_i ? WID_W'(PERF_BASE) : WID_W'(SIG_BASE))
                  + WID_W'(tbl_size_i) - WID_W'(1);
        for (int b = 0; b < HASH_W; b++) begin
            mask[b] = (WID_W'(b) < keep_w);
        end
        if (error_o) begin
            bucket_o = '0;
            word_o   = '0;
        end else begin
            bucket_o = bucket_raw_i & mask;
            word_o   = {(perfect_i ? sw_index_i : sig_raw_i), bucket_o};
        end
    end

endmodule

// File: rtl/flow_hash_top.sv
module flow_hash_top
    import flow_hash_pkg::*;
#(
    parameter int WORD_W    = FH_WORD_W,
    parameter int NUM_WORDS = FH_NUM_WORDS,
    parameter int HASH_W    = FH_HASH_W,
    parameter int SIZE_W    = FH_SIZE_W,
    parameter int PERF_BASE = FH_PERF_BASE,
    parameter int SIG_BASE  = FH_SIG_BASE
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [WORD_W*NUM_WORDS-1:0] tuple,
    input  logic [WORD_W-1:0]           bucket_key,
    input  logic [WORD_W-1:0]           sig_key,
    input  logic [SIZE_W-1:0]           tbl_size,
    input  logic                        perfect_mode,
    input  logic [HASH_W-1:0]           sw_index,
    output logic                        out_valid,
    output logic [HASH_W-1:0]           out_bucket,
    output logic [2*HASH_W-1:0]         out_hash,
    output logic                        out_error
);
    localparam int NUM_KEYS = 2;

    fh_state_t st_d, st_q;

    logic [WORD_W-1:0] hi_w, lo_plain_w, lo_mixed_w;
    logic [WORD_W-1:0] keys [NUM_KEYS];
    logic [HASH_W-1:0] raw  [NUM_KEYS];
    logic [HASH_W-1:0] bucket_c;
    logic [2*HASH_W-1:0] word_c;
    logic              error_c;
    logic              accept;

    assign keys[0] = bucket_key;
    assign keys[1] = sig_key;

    flow_hash_fold #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_fold (
        .tuple_i    (tuple),
        .hi_o       (hi_w),
        .lo_plain_o (lo_plain_w),
        .lo_mixed_o (lo_mixed_w)
    );

    generate
        for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
            flow_hash_keyed #(.WORD_W(WORD_W), .HASH_W(HASH_W)) u_keyed (
                .key_i      (keys[k]),
                .hi_i       (hi_w),
                .lo_plain_i (lo_plain_w),
                .lo_mixed_i (lo_mixed_w),
                .hash_o     (raw[k])
            );
        end
    endgenerate

    flow_hash_compose #(
        .HASH_W(HASH_W), .SIZE_W(SIZE_W),
        .PERF_BASE(PERF_BASE), .SIG_BASE(SIG_BASE)
    ) u_compose (
        .bucket_raw_i (raw[0]),
        .sig_raw_i    (raw[1]),
        .tbl_size_i   (tbl_size),
        .perfect_i    (perfect_mode),
        .sw_index_i   (sw_index),
        .bucket_o     (bucket_c),
        .word_o       (word_c),
        .error_o      (error_c)
    );

    assign accept = in_valid && st_q.ready;

    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b1;
        st_d.valid = accept;
        if (accept) begin
            st_d.error  = error_c;
            st_d.bucket = bucket_c;
            st_d.hash   = word_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready   = st_q.ready;
    assign out_valid  = st_q.valid;
    assign out_error  = st_q.error;
    assign out_bucket = st_q.bucket;
    assign out_hash   = st_q.hash;

    // R9: one strobe per accepted request, and none otherwise
    assert_valid_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
    assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !out_valid);
    assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> ($stable(out_hash) && $stable(out_bucket)));

    // R5 / R6: bucket never exceeds the width chosen by size and mode
    assert_bucket_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_error && !$past(perfect_mode)) |->
        ({1'b0, out_bucket} < ((HASH_W+1)'(1) << (SIG_BASE + int'($past(tbl_size)) - 1))));
    assert_bucket_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_error && $past(perfect_mode)) |->
        ({1'b0, out_bucket} < ((HASH_W+1)'(1) << (PERF_BASE + int'($past(tbl_size)) - 1))));

    // R8: software index lands in the upper field
    assert_swindex_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_error && $past(perfect_mode)) |->
        (out_hash[2*HASH_W-1:HASH_W] == $past(sw_index)));

    // R7: a zero signature key gives a zero upper field
    assert_zero_sigkey_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !perfect_mode && tbl_size != '0 && sig_key == '0) |=>
        (out_hash[2*HASH_W-1:HASH_W] == '0));

    // R10: illegal size flagged with cleared result
    assert_bad_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && tbl_size == '0) |=>
        (out_error && out_hash == '0 && out_bucket == '0));

    // R11: ready stays up once out of reset
    assert_ready_up_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> in_ready);

endmodule

// File: tb/tb_flow_hash_top.sv
module tb_flow_hash_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [351:0] tuple;
    logic [31:0]  bucket_key, sig_key;
    logic [1:0]   tbl_size;
    logic         perfect_mode;
    logic [15:0]  sw_index;
    logic         out_valid;
    logic [15:0]  out_bucket;
    logic [31:0]  out_hash;
    logic         out_error;

    int checks   = 0;
    int failures = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #5 clk = ~clk;

    flow_hash_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .tuple(tuple), .bucket_key(bucket_key), .sig_key(sig_key),
        .tbl_size(tbl_size), .perfect_mode(perfect_mode), .sw_index(sw_index),
        .out_valid(out_valid), .out_bucket(out_bucket), .out_hash(out_hash),
        .out_error(out_error)
    );

    function automatic logic [15:0] ref_hash(input logic [351:0] t, input logic [31:0] k);
        logic [31:0] c, f, hi, lo, acc;
        c = '0;
        for (int w = 1; w < 11; w++) c ^= t[w*32 +: 32];
        f   = t[31:0];
        hi  = c ^ f ^ (f >> 16);
        lo  = {c[15:0], c[31:16]};
        acc = '0;
        if (k[0])  acc ^= lo;
        if (k[16]) acc ^= hi;
        lo ^= f ^ (f << 16);
        for (int i = 15; i >= 1; i--) begin
            if (k[i])    acc ^= lo >> i;
            if (k[i+16]) acc ^= hi >> i;
        end
        return acc[15:0];
    endfunction

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x ^= x << 13;
        x ^= x >> 17;
        x ^= x << 5;
        return x;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rand_tuple(output logic [351:0] t);
        for (int w = 0; w < 11; w++) begin
            rng = next_rng(rng);
            t[w*32 +: 32] = rng;
        end
    endtask

    // drive one request; on return the result is on the outputs
    task automatic send(input logic [351:0] t, input logic [31:0] bk, input logic [31:0] sk,
                        input logic [1:0] sz, input logic pm, input logic [15:0] si);
        @(negedge clk);
        tuple = t; bucket_key = bk; sig_key = sk;
        tbl_size = sz; perfect_mode = pm; sw_index = si; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_full(input string req, input logic [351:0] t, input logic [31:0] bk,
                               input logic [31:0] sk, input logic [1:0] sz, input logic pm,
                               input logic [15:0] si);
        logic [15:0] mask, eb;
        logic [31:0] eh;
        int keep;
        keep = (pm ? 11 : 13) + int'(sz) - 1;
        mask = '0;
        for (int b = 0; b < 16; b++) mask[b] = (b < keep);
        eb = ref_hash(t, bk) & mask;
        eh = {(pm ? si : ref_hash(t, sk)), eb};
        send(t, bk, sk, sz, pm, si);
        check({req, " valid"},  64'(out_valid),  64'd1);
        check({req, " error"},  64'(out_error),  64'd0);
        check({req, " bucket"}, 64'(out_bucket), 64'(eb));
        check({req, " hash"},   64'(out_hash),   64'(eh));
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b0; tuple = '0; bucket_key = '0; sig_key = '0;
        tbl_size = 2'b01; perfect_mode = 1'b0; sw_index = '0;
        repeat (3) @(negedge clk);
        check("R11 ready in reset", 64'(in_ready), 64'd0);
        check("R9 no valid in reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 ready after reset", 64'(in_ready), 64'd1);
        check("R9 idle valid", 64'(out_valid), 64'd0);
    endtask

    task automatic t_single_key_bits;
        logic [351:0] t;
        logic [31:0] c;
        rand_tuple(t);
        c = '0;
        for (int w = 1; w < 11; w++) c ^= t[w*32 +: 32];
        // R3: key bit 0 alone sees no flow-word contribution on the low side
        send(t, 32'h0000_0001, 32'h0001_0000, 2'b11, 1'b0, 16'h0);
        check("R3 bit0", 64'(out_bucket), 64'(c[31:16] & 16'h7FFF));
        check("R3 bit16", 64'(out_hash[31:16]),
              64'(c[15:0] ^ t[15:0] ^ t[31:16]));
        send(t, 32'h0, 32'h0, 2'b11, 1'b0, 16'h0);
        check("R3 zero key", 64'(out_hash), 64'd0);
        // R4: single shifted terms
        expect_full("R4 bit1", t, 32'h0000_0002, 32'h0002_0000, 2'b11, 1'b0, 16'h0);
        expect_full("R4 bit15", t, 32'h0000_8000, 32'h8000_0000, 2'b11, 1'b0, 16'h0);
    endtask

    task automatic t_fold_order;
        logic [351:0] a, b;
        logic [31:0] x, h1;
        logic [15:0] b1;
        rand_tuple(a);
        rng = next_rng(rng); x = rng;
        b = a;
        b[3*32 +: 32] = a[7*32 +: 32];
        b[7*32 +: 32] = a[3*32 +: 32];
        b[2*32 +: 32] = a[2*32 +: 32] ^ x;
        b[9*32 +: 32] = a[9*32 +: 32] ^ x;
        send(a, 32'hA5C3_0F96, 32'h1E2D_3C4B, 2'b11, 1'b0, 16'h0);
        h1 = out_hash; b1 = out_bucket;
        send(b, 32'hA5C3_0F96, 32'h1E2D_3C4B, 2'b11, 1'b0, 16'h0);
        check("R1 fold hash", 64'(out_hash), 64'(h1));
        check("R1 fold bucket", 64'(out_bucket), 64'(b1));
    endtask

    task automatic t_flow_injection;
        logic [351:0] t;
        rand_tuple(t);
        expect_full("R2 mixed", t, 32'hFFFF_FFFF, 32'h5A5A_A5A5, 2'b11, 1'b0, 16'h0);
        t[31:0] = 32'h8001_0001;
        expect_full("R2 flow word", t, 32'hFFFF_FFFF, 32'h0F0F_F0F0, 2'b11, 1'b0, 16'h0);
    endtask

    task automatic t_sig_sizes;
        logic [351:0] t;
        rand_tuple(t);
        for (int s = 1; s < 4; s++)
            expect_full("R5 R7 sig size", t, 32'hFFFF_FFFF, 32'h3C96_A5F0, 2'(s), 1'b0, 16'h0);
    endtask

    task automatic t_perf_sizes;
        logic [351:0] t;
        rand_tuple(t);
        for (int s = 1; s < 4; s++)
            expect_full("R6 R8 perf size", t, 32'hFFFF_FFFF, 32'h3C96_A5F0, 2'(s), 1'b1, 16'hBEEF);
    endtask

    task automatic t_error;
        logic [351:0] t;
        rand_tuple(t);
        send(t, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, 1'b0, 16'h1234);
        check("R10 error flag", 64'(out_error), 64'd1);
        check("R10 zero hash", 64'(out_hash), 64'd0);
        check("R10 zero bucket", 64'(out_bucket), 64'd0);
        expect_full("R10 recover", t, 32'hFFFF_FFFF, 32'h1111_2222, 2'b10, 1'b0, 16'h0);
    endtask

    task automatic t_timing;
        logic [351:0] t;
        logic [31:0] h;
        rand_tuple(t);
        send(t, 32'h8421_8421, 32'h1248_1248, 2'b10, 1'b1, 16'h7777);
        check("R9 pulse", 64'(out_valid), 64'd1);
        h = out_hash;
        tuple = ~t; sw_index = 16'h0; bucket_key = 32'h0;
        @(negedge clk);
        check("R9 single cycle", 64'(out_valid), 64'd0);
        check("R9 hold", 64'(out_hash), 64'(h));
        @(negedge clk);
        check("R9 hold later", 64'(out_hash), 64'(h));
    endtask

    task automatic t_random;
        logic [351:0] t;
        for (int n = 0; n < 40; n++) begin
            logic [31:0] bk, sk;
            rand_tuple(t);
            rng = next_rng(rng); bk = rng;
            rng = next_rng(rng); sk = rng;
            expect_full("R4 R7 R8 random", t, bk, sk, 2'(1 + (n % 3)), n[0], rng[15:0]);
        end
    endtask

    initial begin
        t_reset;
        t_single_key_bits;
        t_fold_order;
        t_flow_injection;
        t_sig_sizes;
        t_perf_sizes;
        t_error;
        t_timing;
        t_random;
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule